// File: doc/BRIEF.md
# Power-Good Frequency Strap Latch

This block decides the host CPU clock frequency and the output mode of a clock generator from two board straps. One strap is a plain binary level. The other is a three-level strap that an analog detector outside this block has already turned into a 2-bit code. An active-low power-good input tells the block that the processor supply is stable. After a two-flop synchronizer sees that input low for the first time, the block captures both straps on the next clock and then freezes the choice.

A mid level on the three-level strap at capture time puts the block into a sticky test mode. In test mode the binary strap is read live, with no clock involved, and picks between a divided-reference output and high impedance. Only a power-on reset leaves test mode. A register bit written over the serial configuration interface switches the CPU frequency table to its doubled set, and it takes effect at once. Until the capture happens, a valid flag stays low so that downstream logic keeps the clocks gated.

Top module: `freq_strap_latch`

## Requirements
- R1: While `rstN` is low, and after it until the capture, `strapValid`=0, `testMode`=0, `outMode`=2'b00 (normal) and `cpuMhz` reports the default selection (100, or 200 when `tableDouble`=1).
- R2: Suppose `pwrGoodN` goes low while `rstN` is high and stays low. `strapValid` is still 0 after the second rising edge of `clk` that follows, and it is 1 after the third. The straps are sampled at that third edge.
- R3: With `tableDouble`=0, a normal capture maps {`selA`, B high} = 00, 01, 10, 11 to `cpuMhz` = 100, 200, 133, 166. The `selB` code 2'b00 means low and 2'b10 means high.
- R4: With `tableDouble`=1, the same four selections give `cpuMhz` = 200, 400, 266, 333. A change of `tableDouble` takes effect without any capture.
- R5: After a normal capture, later changes on `pwrGoodN`, `selA` and `selB` leave `strapValid`, `testMode`, `outMode` and `cpuMhz` unchanged.
- R6: If `selB` is 2'b01 (mid) at the capture edge, the block sets `testMode`=1 and `strapValid`=1, and `cpuMhz` is 0.
- R7: In test mode, `outMode` follows `selA` with no clock edge: 2'b01 (reference divide) when `selA`=0 and 2'b10 (high impedance) when `selA`=1.
- R8: Test mode is sticky. `selB` and `pwrGoodN` have no effect on it, and only `rstN` low clears it.
- R9: The `selB` code 2'b11 is treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| pwrGoodN | input | 1 | Asynchronous supply-stable indication, active low |
| selA | input | 1 | Binary frequency strap |
| selB | input | 2 | Three-level strap code: 00 low, 01 mid, 10/11 high |
| tableDouble | input | 1 | Register override selecting the doubled frequency table |
| strapValid | output | 1 | Straps have been captured |
| testMode | output | 1 | Test clock mode is active |
| outMode | output | 2 | 00 normal, 01 reference divide, 10 high impedance |
| cpuMhz | output | 9 | Selected CPU frequency in MHz, 0 in test mode |

## Verification
The bench drives all four binary strap pairs through separate reset cycles under both table settings, so that a swapped strap bit or a wrong table entry shows up as a distinct frequency. It also applies code 2'b11 to confirm it is read as high. The power-good edge is timed against the clock to tell a correct two-stage synchronizer apart from one stage too few or too many. After capture, the straps and power-good are toggled to show the one-shot freeze. A mid-level capture is followed by live `selA` changes between clock edges, which separates the asynchronous path from a registered one. Further strap and power-good activity shows that only reset ends test mode.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_REFDIV = 2'b01,
    MODE_HIZ    = 2'b10
  } outMode_e;

  localparam logic [1:0] LVL_LOW  = 2'b00;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_HIGH = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch straps this cycle
    logic locked;   // capture has already happened
  } ctrlStrobe_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGoodN,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_ARMED, ST_LOCKED} ctrlState_e;

  ctrlState_e state;
  logic       pgLowSync;

  generate
    if (SYNC_STAGES >= 2) begin : g_chain
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pwrGoodN};
      end
      assign pgLowSync = ~syncChain[SYNC_STAGES-1];
    end else begin : g_single
      logic syncOne;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncOne <= 1'b1;
        else       syncOne <= pwrGoodN;
      end
      assign pgLowSync = ~syncOne;
    end
  endgenerate

  always_comb begin
    strobe.capture = (state == ST_ARMED) && pgLowSync;
    strobe.locked  = (state == ST_LOCKED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               state <= ST_ARMED;
    else if (strobe.capture) state <= ST_LOCKED;
  end

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.locked |=> strobe.locked && !strobe.capture);

  // R2
  capture_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.locked);

endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
#(
  parameter int FREQ_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              selA,
  input  logic [1:0]        selB,
  input  logic              tableDouble,
  output logic              strapValid,
  output logic              testMode,
  output logic [1:0]        outMode,
  output logic [FREQ_W-1:0] cpuMhz
);

  logic validQ, testQ, latA, latBHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      testQ    <= 1'b0;
      latA     <= 1'b0;
      latBHigh <= 1'b0;
    end else if (strobe.capture) begin
      validQ   <= 1'b1;
      testQ    <= (selB == LVL_MID);
      latA     <= selA;
      latBHigh <= selB[1];
    end
  end

  function automatic logic [FREQ_W-1:0] lookupMhz(input logic a, input logic bHigh,
                                                   input logic dbl);
    logic [FREQ_W-1:0] v;
    case ({dbl, a, bHigh})
      3'b000:  v = FREQ_W'(100);
      3'b001:  v = FREQ_W'(200);
      3'b010:  v = FREQ_W'(133);
      3'b011:  v = FREQ_W'(166);
      3'b100:  v = FREQ_W'(200);
      3'b101:  v = FREQ_W'(400);
      3'b110:  v = FREQ_W'(266);
      default: v = FREQ_W'(333);
    endcase
    return v;
  endfunction

  always_comb begin
    strapValid = validQ;
    testMode   = testQ;
    cpuMhz     = testQ ? '0 : lookupMhz(latA, latBHigh, tableDouble);
    if (testQ) outMode = selA ? MODE_HIZ : MODE_REFDIV;
    else       outMode = MODE_NORMAL;
  end

  // R2
  lock_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.locked == strapValid);

  // R5
  latched_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strapValid && $past(strapValid)) |-> ($stable(latA) && $stable(latBHigh) && $stable(testQ)));

  // R6
  mid_enters_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && selB == LVL_MID) |=> testMode);

  // R8
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    testMode |=> testMode);

  // R1
  normal_before_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strapValid |-> (outMode == MODE_NORMAL && !testMode));

endmodule

// File: rtl/freq_strap_latch.sv
module freq_strap_latch
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FREQ_W      = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrGoodN,
  input  logic              selA,
  input  logic [1:0]        selB,
  input  logic              tableDouble,
  output logic              strapValid,
  output logic              testMode,
  output logic [1:0]        outMode,
  output logic [FREQ_W-1:0] cpuMhz
);

  ctrlStrobe_t strobe;

  strap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrGoodN (pwrGoodN),
    .strobe   (strobe)
  );

  strap_dp #(.FREQ_W(FREQ_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .selA        (selA),
    .selB        (selB),
    .tableDouble (tableDouble),
    .strapValid  (strapValid),
    .testMode    (testMode),
    .outMode     (outMode),
    .cpuMhz      (cpuMhz)
  );

endmodule

// File: tb/test_freq_strap_latch.sv
module test_freq_strap_latch;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGoodN = 1'b1;
  logic       selA = 1'b0;
  logic [1:0] selB = 2'b00;
  logic       tableDouble = 1'b0;
  logic       strapValid, testMode;
  logic [1:0] outMode;
  logic [8:0] cpuMhz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic       v;
    logic       t;
    logic [1:0] m;
    logic [8:0] f;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  always #10 clk = ~clk;

  freq_strap_latch i_freq_strap_latch (
    .clk(clk), .rstN(rstN), .pwrGoodN(pwrGoodN), .selA(selA), .selB(selB),
    .tableDouble(tableDouble), .strapValid(strapValid), .testMode(testMode),
    .outMode(outMode), .cpuMhz(cpuMhz)
  );

  // monitor: pops expectations and compares with outputs
  initial begin
    forever begin
      expItem_t it;
      wait (scoreQ.size() > 0);
      it = scoreQ.pop_front();
      checks++;
      if (strapValid !== it.v || testMode !== it.t || outMode !== it.m || cpuMhz !== it.f) begin
        errors++;
        $display("FAIL %s: got valid=%0b test=%0b mode=%0b mhz=%0d, exp valid=%0b test=%0b mode=%0b mhz=%0d",
                 it.tag, strapValid, testMode, outMode, cpuMhz, it.v, it.t, it.m, it.f);
      end
    end
  end

  task automatic expectOut(input logic v, input logic t, input logic [1:0] m,
                           input logic [8:0] f, input string tag);
    expItem_t it;
    it.v = v; it.t = t; it.m = m; it.f = f; it.tag = tag;
    scoreQ.push_back(it);
    wait (scoreQ.size() == 0);
    #1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pwrGoodN = 1'b1;
    cycles(2);
    rstN = 1'b1;
    cycles(1);
  endtask

  task automatic captureWith(input logic a, input logic [1:0] b);
    selA = a; selB = b;
    pwrGoodN = 1'b0;
    cycles(3);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(1);
    // R1: reset state
    expectOut(1'b0, 1'b0, 2'b00, 9'd100, "R1 during reset");
    rstN = 1'b1;
    cycles(2);
    expectOut(1'b0, 1'b0, 2'b00, 9'd100, "R1 before capture");
    tableDouble = 1'b1; #1;
    expectOut(1'b0, 1'b0, 2'b00, 9'd200, "R4 doubled default before capture");
    tableDouble = 1'b0;

    // R2: capture latency, straps A=1 B=high
    selA = 1'b1; selB = 2'b10;
    pwrGoodN = 1'b0;
    cycles(2);
    expectOut(1'b0, 1'b0, 2'b00, 9'd100, "R2 not valid after two edges");
    cycles(1);
    expectOut(1'b1, 1'b0, 2'b00, 9'd166, "R2 R3 valid after third edge A1 Bhigh");

    // R5: later activity ignored
    selA = 1'b0; selB = 2'b00; pwrGoodN = 1'b1;
    cycles(4);
    pwrGoodN = 1'b0; selB = 2'b01;
    cycles(4);
    expectOut(1'b1, 1'b0, 2'b00, 9'd166, "R5 frozen after capture");
    tableDouble = 1'b1; #1;
    expectOut(1'b1, 1'b0, 2'b00, 9'd333, "R4 live double A1 Bhigh");
    tableDouble = 1'b0;

    // R3 / R4: remaining table entries
    doReset(); captureWith(1'b0, 2'b00);
    expectOut(1'b1, 1'b0, 2'b00, 9'd100, "R3 A0 Blow");
    tableDouble = 1'b1; #1;
    expectOut(1'b1, 1'b0, 2'b00, 9'd200, "R4 A0 Blow");
    tableDouble = 1'b0;

    doReset(); captureWith(1'b0, 2'b10);
    expectOut(1'b1, 1'b0, 2'b00, 9'd200, "R3 A0 Bhigh");
    tableDouble = 1'b1; #1;
    expectOut(1'b1, 1'b0, 2'b00, 9'd400, "R4 A0 Bhigh");
    tableDouble = 1'b0;

    doReset(); captureWith(1'b1, 2'b00);
    expectOut(1'b1, 1'b0, 2'b00, 9'd133, "R3 A1 Blow");
    tableDouble = 1'b1; #1;
    expectOut(1'b1, 1'b0, 2'b00, 9'd266, "R4 A1 Blow");
    tableDouble = 1'b0;

    // R9: code 11 as high
    doReset(); captureWith(1'b0, 2'b11);
    expectOut(1'b1, 1'b0, 2'b00, 9'd200, "R9 code 11 reads high");

    // R6 / R7: test mode
    doReset(); captureWith(1'b0, 2'b01);
    expectOut(1'b1, 1'b1, 2'b01, 9'd0, "R6 mid enters test, refdiv");
    #3 selA = 1'b1; #2;
    expectOut(1'b1, 1'b1, 2'b10, 9'd0, "R7 selA=1 hi-z without edge");
    selA = 1'b0; #2;
    expectOut(1'b1, 1'b1, 2'b01, 9'd0, "R7 selA=0 refdiv without edge");

    // R8: sticky test mode
    cycles(1);
    selB = 2'b00; pwrGoodN = 1'b1;
    cycles(4);
    pwrGoodN = 1'b0; selB = 2'b10;
    cycles(4);
    expectOut(1'b1, 1'b1, 2'b01, 9'd0, "R8 test mode ignores selB and power-good");
    doReset();
    expectOut(1'b0, 1'b0, 2'b00, 9'd100, "R8 reset leaves test mode");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule